// File: doc/BRIEF.md
# Stack-machine ALU and register datapath

This block is the data path of a 21-bit two-stack processor. It holds a top-of-stack register T, a data stack of 18 entries sitting underneath T, a return stack of 17 entries of 21 bits, and a data address register A. Each cycle in which `op_valid` is high, the block carries out the 5-bit operation on `op_code`. The operation can be arithmetic, logic, a shift, a stack move, or the register side of a memory load or store. Every operation finishes in one clock edge.

The branch logic reads two flags. `carry_flag` is T bit 20, and `t_zero` reports that the low 20 bits of T are zero. Memory accesses take their address from A or from the top of the return stack. Load data arrives on `mem_rdata` and is pushed into T in the same cycle. Store data is T itself, and a store drops T afterwards.

The stacks are circular. A push beyond the depth overwrites the oldest entry. A pop past the bottom brings back entries that are still held in the cells. The bound checker prints a note when either stack is pushed past its depth.

Top module: `stk_core`

## Requirements
- R1: After a synchronous active-high reset, T, A, the data stack top and the return stack top all read zero, and `mem_rd` and `mem_wr` are low.
- R2: Code 0x10 sets T to the bitwise complement of all 21 bits. Code 0x11 shifts T left by one, so that 0 enters bit 0 and bit 19 moves into bit 20. Code 0x12 shifts T right by one, keeping bit 20 and also copying it into bit 19. None of these three codes touches the data stack.
- R3: Codes 0x14 (XOR), 0x15 (AND) and 0x17 (ADD) combine the data stack top S with T, write the result to T, and pop the data stack. XOR and AND act on all 21 bits. ADD sums the low 20 bits of S and T and puts the carry out of bit 19 into bit 20.
- R4: Code 0x13 performs the same 20-bit add as 0x17 only when T bit 0 is 1, and leaves T unchanged otherwise. In both cases the data stack is left as it was, with no pop.
- R5: `carry_flag` equals T bit 20. `t_zero` is high exactly when T bits 19..0 are all zero.
- R6: Code 0x1A pushes T onto the data stack and keeps T. Code 0x1B pushes T and loads T with the old S. Code 0x19 pushes T and loads T with A.
- R7: Code 0x1F drops T, refilling it from S with a pop. Code 0x1D moves T into A, and T is likewise refilled from S with a pop.
- R8: Code 0x1C pushes T onto the return stack and refills T from S with a pop. Code 0x18 pops the return stack top into T and pushes the old T onto the data stack.
- R9: Codes 0x08, 0x09 and 0x0B raise `mem_rd` and push `mem_rdata` into T, with the old T going onto the data stack. Code 0x0A pushes `mem_rdata` the same way but does not raise `mem_rd`. Code 0x08 addresses memory with the return stack top and then adds 1 to it. Code 0x09 addresses memory with A and then adds 1 to A, wrapping at 21 bits. Code 0x0B addresses memory with A and leaves A unchanged.
- R10: Codes 0x0C, 0x0D and 0x0F raise `mem_wr` with `mem_wdata` equal to T, then drop T, refilling it from S. Code 0x0C uses the return stack top as the address and then increments it. Code 0x0D uses A as the address and then increments A. Code 0x0F uses A and leaves it unchanged.
- R11: Code 0x1E, codes 0x00 to 0x07, 0x0E and 0x16, and any cycle in which `op_valid` is low leave T, A and both stack tops unchanged, and raise neither `mem_rd` nor `mem_wr`.
- R12: Both stacks are circular. Pushing beyond the depth (18 data, 17 return) overwrites the oldest entry. Popping past the bottom yields the held entries again, in their original order, starting from the most recent survivor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 5 | Operation code |
| mem_rdata | input | 21 | Fetched data or in-line literal |
| mem_rd | output | 1 | Data load request this cycle |
| mem_wr | output | 1 | Data store request this cycle |
| mem_addr | output | 21 | Data address: A, or return stack top for 0x08/0x0C |
| mem_wdata | output | 21 | Store data (T) |
| t_top | output | 21 | T register |
| s_top | output | 21 | Data stack top (entry under T) |
| r_top | output | 21 | Return stack top |
| a_reg | output | 21 | Address register A |
| carry_flag | output | 1 | T bit 20 |
| t_zero | output | 1 | T bits 19..0 all zero |

## Verification
The properties assume that `op_code` and `mem_rdata` are stable for the whole cycle in which `op_valid` is high. They also assume that reset is held until the first edge with `op_valid` low. The stimulus drives every input on the falling edge and never changes it near the rising edge. The bench repeats a sweep of all 32 codes for six operand sets, which are chosen to cover carry out of bit 19, the sign bit in the right shift and the wrap of A and R from all ones. The overflow and underflow runs check circular reuse of the cells, and they depend on the checker only noting an overflow rather than failing on it.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam int XLEN    = 21;
    localparam int DBITS   = 20;
    localparam int S_DEPTH = 18;
    localparam int R_DEPTH = 17;

    typedef logic [XLEN-1:0] word_t;
    typedef logic [4:0]      opc_t;

    localparam opc_t OPC_FETCH_R  = 5'h08;
    localparam opc_t OPC_FETCH_AI = 5'h09;
    localparam opc_t OPC_LIT      = 5'h0A;
    localparam opc_t OPC_FETCH_A  = 5'h0B;
    localparam opc_t OPC_STORE_R  = 5'h0C;
    localparam opc_t OPC_STORE_AI = 5'h0D;
    localparam opc_t OPC_STORE_A  = 5'h0F;
    localparam opc_t OPC_INV      = 5'h10;
    localparam opc_t OPC_SHL      = 5'h11;
    localparam opc_t OPC_SHR      = 5'h12;
    localparam opc_t OPC_MSTEP    = 5'h13;
    localparam opc_t OPC_XOR      = 5'h14;
    localparam opc_t OPC_AND      = 5'h15;
    localparam opc_t OPC_ADD      = 5'h17;
    localparam opc_t OPC_RFROM    = 5'h18;
    localparam opc_t OPC_AFETCH   = 5'h19;
    localparam opc_t OPC_DUP      = 5'h1A;
    localparam opc_t OPC_OVER     = 5'h1B;
    localparam opc_t OPC_TOR      = 5'h1C;
    localparam opc_t OPC_ASTORE   = 5'h1D;
    localparam opc_t OPC_NOP      = 5'h1E;
    localparam opc_t OPC_DROP     = 5'h1F;

    typedef enum logic [1:0] {SK_HOLD, SK_PUSH, SK_POP, SK_BUMP} stk_op_e;
    typedef enum logic [2:0] {TS_KEEP, TS_ALU, TS_SNEXT, TS_RTOP, TS_AREG, TS_MEM} tsel_e;
    typedef enum logic [1:0] {AS_KEEP, AS_INC, AS_LOAD} asel_e;

    typedef struct packed {
        tsel_e   tsel;
        stk_op_e s_op;
        stk_op_e r_op;
        asel_e   a_op;
        logic    rd;
        logic    wr;
        logic    via_r;
    } ctrl_t;

    function automatic word_t add_lo(word_t a, word_t b);
        return {1'b0, a[DBITS-1:0]} + {1'b0, b[DBITS-1:0]};
    endfunction

    function automatic word_t shl1(word_t a);
        return {a[XLEN-2:0], 1'b0};
    endfunction

    function automatic word_t sar1(word_t a);
        return {a[XLEN-1], a[XLEN-1:1]};
    endfunction

    function automatic ctrl_t decode(opc_t op, logic valid);
        ctrl_t c;
        c = '{tsel: TS_KEEP, s_op: SK_HOLD, r_op: SK_HOLD, a_op: AS_KEEP,
              rd: 1'b0, wr: 1'b0, via_r: 1'b0};
        if (valid) begin
            case (op)
                OPC_INV, OPC_SHL, OPC_SHR, OPC_MSTEP: c.tsel = TS_ALU;
                OPC_XOR, OPC_AND, OPC_ADD: begin
                    c.tsel = TS_ALU;   c.s_op = SK_POP;
                end
                OPC_RFROM: begin
                    c.tsel = TS_RTOP;  c.s_op = SK_PUSH;  c.r_op = SK_POP;
                end
                OPC_AFETCH: begin
                    c.tsel = TS_AREG;  c.s_op = SK_PUSH;
                end
                OPC_DUP:  c.s_op = SK_PUSH;
                OPC_OVER: begin
                    c.tsel = TS_SNEXT; c.s_op = SK_PUSH;
                end
                OPC_TOR: begin
                    c.tsel = TS_SNEXT; c.s_op = SK_POP;   c.r_op = SK_PUSH;
                end
                OPC_ASTORE: begin
                    c.tsel = TS_SNEXT; c.s_op = SK_POP;   c.a_op = AS_LOAD;
                end
                OPC_DROP: begin
                    c.tsel = TS_SNEXT; c.s_op = SK_POP;
                end
                OPC_FETCH_R: begin
                    c.tsel = TS_MEM;   c.s_op = SK_PUSH;  c.r_op = SK_BUMP;
                    c.rd = 1'b1;       c.via_r = 1'b1;
                end
                OPC_FETCH_AI: begin
                    c.tsel = TS_MEM;   c.s_op = SK_PUSH;  c.a_op = AS_INC;
                    c.rd = 1'b1;
                end
                OPC_LIT: begin
                    c.tsel = TS_MEM;   c.s_op = SK_PUSH;
                end
                OPC_FETCH_A: begin
                    c.tsel = TS_MEM;   c.s_op = SK_PUSH;  c.rd = 1'b1;
                end
                OPC_STORE_R: begin
                    c.tsel = TS_SNEXT; c.s_op = SK_POP;   c.r_op = SK_BUMP;
                    c.wr = 1'b1;       c.via_r = 1'b1;
                end
                OPC_STORE_AI: begin
                    c.tsel = TS_SNEXT; c.s_op = SK_POP;   c.a_op = AS_INC;
                    c.wr = 1'b1;
                end
                OPC_STORE_A: begin
                    c.tsel = TS_SNEXT; c.s_op = SK_POP;   c.wr = 1'b1;
                end
                default: ;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/stk_lifo.sv
module stk_lifo
    import stk_pkg::*;
#(
    parameter int DEPTH = 18,
    parameter int WIDTH = 21
) (
    input  logic             clk,
    input  logic             rst,
    input  stk_op_e          op,
    input  logic [WIDTH-1:0] push_val,
    output logic [WIDTH-1:0] top
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [PW-1:0]    ptr_q;
    logic [PW-1:0]    ptr_up;
    logic [PW-1:0]    ptr_dn;
    logic [PW-1:0]    wr_idx;
    logic             wr_en;
    logic [WIDTH-1:0] wr_val;
    logic [WIDTH-1:0] cells [DEPTH];

    assign ptr_up = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    assign ptr_dn = (ptr_q == '0) ? LAST : ptr_q - 1'b1;
    assign top    = cells[ptr_q];

    always_comb begin
        wr_en  = 1'b0;
        wr_idx = ptr_q;
        wr_val = push_val;
        case (op)
            SK_PUSH: begin
                wr_en  = 1'b1;
                wr_idx = ptr_up;
            end
            SK_BUMP: begin
                wr_en  = 1'b1;
                wr_val = cells[ptr_q] + 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else begin
            case (op)
                SK_PUSH: ptr_q <= ptr_up;
                SK_POP:  ptr_q <= ptr_dn;
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                cells[g] <= '0;
            end else if (wr_en && (wr_idx == PW'(g))) begin
                cells[g] <= wr_val;
            end
        end
    end

endmodule

// File: rtl/stk_alu.sv
module stk_alu
    import stk_pkg::*;
(
    input  opc_t  op,
    input  word_t t_in,
    input  word_t s_in,
    output word_t res
);
    word_t sum;

    assign sum = add_lo(t_in, s_in);

    always_comb begin
        case (op)
            OPC_INV:   res = ~t_in;
            OPC_SHL:   res = shl1(t_in);
            OPC_SHR:   res = sar1(t_in);
            OPC_MSTEP: res = t_in[0] ? sum : t_in;
            OPC_XOR:   res = t_in ^ s_in;
            OPC_AND:   res = t_in & s_in;
            OPC_ADD:   res = sum;
            default:   res = t_in;
        endcase
    end

endmodule

// File: rtl/stk_core.sv
module stk_core
    import stk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        op_valid,
    input  logic [4:0]  op_code,
    input  logic [20:0] mem_rdata,
    output logic        mem_rd,
    output logic        mem_wr,
    output logic [20:0] mem_addr,
    output logic [20:0] mem_wdata,
    output logic [20:0] t_top,
    output logic [20:0] s_top,
    output logic [20:0] r_top,
    output logic [20:0] a_reg,
    output logic        carry_flag,
    output logic        t_zero
);
    ctrl_t ctl;
    word_t t_q, t_d;
    word_t a_q;
    word_t alu_res;
    word_t s_top_w;
    word_t r_top_w;

    assign ctl = decode(op_code, op_valid);

    stk_alu u_alu (
        .op   (op_code),
        .t_in (t_q),
        .s_in (s_top_w),
        .res  (alu_res)
    );

    stk_lifo #(.DEPTH(S_DEPTH), .WIDTH(XLEN)) u_dstk (
        .clk      (clk),
        .rst      (rst),
        .op       (ctl.s_op),
        .push_val (t_q),
        .top      (s_top_w)
    );

    stk_lifo #(.DEPTH(R_DEPTH), .WIDTH(XLEN)) u_rstk (
        .clk      (clk),
        .rst      (rst),
        .op       (ctl.r_op),
        .push_val (t_q),
        .top      (r_top_w)
    );

    always_comb begin
        case (ctl.tsel)
            TS_ALU:   t_d = alu_res;
            TS_SNEXT: t_d = s_top_w;
            TS_RTOP:  t_d = r_top_w;
            TS_AREG:  t_d = a_q;
            TS_MEM:   t_d = mem_rdata;
            default:  t_d = t_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            t_q <= '0;
            a_q <= '0;
        end else begin
            t_q <= t_d;
            case (ctl.a_op)
                AS_INC:  a_q <= a_q + 1'b1;
                AS_LOAD: a_q <= t_q;
                default: ;
            endcase
        end
    end

    assign mem_rd     = ctl.rd;
    assign mem_wr     = ctl.wr;
    assign mem_addr   = ctl.via_r ? r_top_w : a_q;
    assign mem_wdata  = t_q;
    assign t_top      = t_q;
    assign s_top      = s_top_w;
    assign r_top      = r_top_w;
    assign a_reg      = a_q;
    assign carry_flag = t_q[XLEN-1];
    assign t_zero     = (t_q[DBITS-1:0] == '0);

endmodule

// File: rtl/stk_core_chk.sv
module stk_core_chk
    import stk_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        op_valid,
    input logic [4:0]  op_code,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic [20:0] mem_addr,
    input logic [20:0] mem_wdata,
    input logic [20:0] t_top,
    input logic [20:0] s_top,
    input logic [20:0] r_top,
    input logic [20:0] a_reg
);
    localparam int CW = $clog2(S_DEPTH + 2);

    logic [CW-1:0] s_cnt, r_cnt;
    logic s_push, s_pop, r_push, r_pop, is_idle;

    assign s_push = op_valid && (op_code inside {OPC_FETCH_R, OPC_FETCH_AI, OPC_LIT,
                    OPC_FETCH_A, OPC_RFROM, OPC_AFETCH, OPC_DUP, OPC_OVER});
    assign s_pop  = op_valid && (op_code inside {OPC_XOR, OPC_AND, OPC_ADD, OPC_TOR,
                    OPC_ASTORE, OPC_DROP, OPC_STORE_R, OPC_STORE_AI, OPC_STORE_A});
    assign r_push = op_valid && (op_code == OPC_TOR);
    assign r_pop  = op_valid && (op_code == OPC_RFROM);
    assign is_idle = !op_valid || (op_code == OPC_NOP);

    // R12: overflow is only reported as a note
    always_ff @(posedge clk) begin
        if (rst) begin
            s_cnt <= '0;
            r_cnt <= '0;
        end else begin
            if (s_push) begin
                if (s_cnt == CW'(S_DEPTH)) $display("note: data stack pushed past depth");
                else s_cnt <= s_cnt + 1'b1;
            end else if (s_pop && s_cnt != '0) begin
                s_cnt <= s_cnt - 1'b1;
            end
            if (r_push) begin
                if (r_cnt == CW'(R_DEPTH)) $display("note: return stack pushed past depth");
                else r_cnt <= r_cnt + 1'b1;
            end else if (r_pop && r_cnt != '0) begin
                r_cnt <= r_cnt - 1'b1;
            end
        end
    end

    p_inv_r2: assert property (@(posedge clk) disable iff (rst)
        op_valid && op_code == OPC_INV |=> t_top == ~$past(t_top) && s_top == $past(s_top));

    p_add_pop_r3: assert property (@(posedge clk) disable iff (rst)
        op_valid && op_code == OPC_ADD |=>
            t_top == ({1'b0, $past(t_top[19:0])} + {1'b0, $past(s_top[19:0])}));

    p_mstep_keep_s_r4: assert property (@(posedge clk) disable iff (rst)
        op_valid && op_code == OPC_MSTEP |=> s_top == $past(s_top));

    p_dup_r6: assert property (@(posedge clk) disable iff (rst)
        op_valid && op_code == OPC_DUP |=> t_top == $past(t_top) && s_top == $past(t_top));

    p_drop_r7: assert property (@(posedge clk) disable iff (rst)
        op_valid && op_code == OPC_DROP |=> t_top == $past(s_top));

    p_tor_r8: assert property (@(posedge clk) disable iff (rst)
        op_valid && op_code == OPC_TOR |=> r_top == $past(t_top) && t_top == $past(s_top));

    p_fetch_inc_r9: assert property (@(posedge clk) disable iff (rst)
        op_valid && op_code == OPC_FETCH_AI |-> mem_rd && mem_addr == a_reg
            ##1 a_reg == $past(a_reg) + 21'd1);

    p_store_r10: assert property (@(posedge clk) disable iff (rst)
        op_valid && op_code == OPC_STORE_A |-> mem_wr && !mem_rd && mem_wdata == t_top
            && mem_addr == a_reg);

    p_idle_r11: assert property (@(posedge clk) disable iff (rst)
        is_idle |-> !mem_rd && !mem_wr ##1 t_top == $past(t_top) && a_reg == $past(a_reg)
            && s_top == $past(s_top) && r_top == $past(r_top));

endmodule

bind stk_core stk_core_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .t_top     (t_top),
    .s_top     (s_top),
    .r_top     (r_top),
    .a_reg     (a_reg)
);

// File: tb/sim_stk_core.sv
`timescale 1ns/1ps
module sim_stk_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [4:0]  op_code = 5'h1E;
    logic [20:0] mem_rdata = '0;
    logic        mem_rd, mem_wr, carry_flag, t_zero;
    logic [20:0] mem_addr, mem_wdata, t_top, s_top, r_top, a_reg;

    always #5 clk = ~clk;

    stk_core u0 (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .t_top(t_top),
        .s_top(s_top), .r_top(r_top), .a_reg(a_reg),
        .carry_flag(carry_flag), .t_zero(t_zero)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // reference state: index 0 is the top of each stack
    logic [20:0] mt, ma;
    logic [20:0] ms [18];
    logic [20:0] mr [17];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [20:0] act, input logic [20:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%06h expected=%06h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        mt = '0; ma = '0;
        for (int i = 0; i < 18; i++) ms[i] = '0;
        for (int i = 0; i < 17; i++) mr[i] = '0;
    endtask

    task automatic s_push(input logic [20:0] v);
        for (int i = 17; i > 0; i--) ms[i] = ms[i-1];
        ms[0] = v;
    endtask

    task automatic s_pop(output logic [20:0] v);
        v = ms[0];
        for (int i = 0; i < 17; i++) ms[i] = ms[i+1];
        ms[17] = v;
    endtask

    task automatic r_push(input logic [20:0] v);
        for (int i = 16; i > 0; i--) mr[i] = mr[i-1];
        mr[0] = v;
    endtask

    task automatic r_pop(output logic [20:0] v);
        v = mr[0];
        for (int i = 0; i < 16; i++) mr[i] = mr[i+1];
        mr[16] = v;
    endtask

    function automatic logic [20:0] add20(input logic [20:0] a, input logic [20:0] b);
        logic [20:0] r;
        r = 21'(a[19:0]) + 21'(b[19:0]);
        return r;
    endfunction

    function automatic string tag_of(input logic [4:0] op);
        case (op)
            5'h10, 5'h11, 5'h12:         return "R2";
            5'h14, 5'h15, 5'h17:         return "R3";
            5'h13:                       return "R4";
            5'h19, 5'h1A, 5'h1B:         return "R6";
            5'h1D, 5'h1F:                return "R7";
            5'h18, 5'h1C:                return "R8";
            5'h08, 5'h09, 5'h0A, 5'h0B:  return "R9";
            5'h0C, 5'h0D, 5'h0F:         return "R10";
            default:                     return "R11";
        endcase
    endfunction

    task automatic model_apply(input logic [4:0] op, input logic [20:0] d);
        logic [20:0] v, s0;
        s0 = ms[0];
        case (op)
            5'h10: mt = ~mt;
            5'h11: mt = {mt[19:0], 1'b0};
            5'h12: mt = {mt[20], mt[20], mt[19:1]};
            5'h13: if (mt[0]) mt = add20(mt, s0);
            5'h14: begin s_pop(v); mt = mt ^ v; end
            5'h15: begin s_pop(v); mt = mt & v; end
            5'h17: begin s_pop(v); mt = add20(mt, v); end
            5'h18: begin s_push(mt); r_pop(v); mt = v; end
            5'h19: begin s_push(mt); mt = ma; end
            5'h1A: s_push(mt);
            5'h1B: begin s_push(mt); mt = s0; end
            5'h1C: begin r_push(mt); s_pop(v); mt = v; end
            5'h1D: begin ma = mt; s_pop(v); mt = v; end
            5'h1F: begin s_pop(v); mt = v; end
            5'h08: begin s_push(mt); mt = d; mr[0] = mr[0] + 21'd1; end
            5'h09: begin s_push(mt); mt = d; ma = ma + 21'd1; end
            5'h0A, 5'h0B: begin s_push(mt); mt = d; end
            5'h0C: begin s_pop(v); mt = v; mr[0] = mr[0] + 21'd1; end
            5'h0D: begin s_pop(v); mt = v; ma = ma + 21'd1; end
            5'h0F: begin s_pop(v); mt = v; end
            default: ;
        endcase
    endtask

    task automatic compare_state(input string tag);
        chk(t_top == mt, tag, "T", t_top, mt);
        chk(s_top == ms[0], tag, "S top", s_top, ms[0]);
        chk(r_top == mr[0], tag, "R top", r_top, mr[0]);
        chk(a_reg == ma, tag, "A", a_reg, ma);
        chk(carry_flag == mt[20], "R5", "carry_flag", 21'(carry_flag), 21'(mt[20]));
        chk(t_zero == (mt[19:0] == 0), "R5", "t_zero", 21'(t_zero), 21'(mt[19:0] == 0));
    endtask

    // one strobed operation; tag "" selects the tag of the opcode
    task automatic step(input logic [4:0] op, input logic [20:0] d, input bit valid,
                        input string tag_in);
        string tag;
        bit exp_rd, exp_wr;
        logic [20:0] exp_addr;
        tag = (tag_in == "") ? (valid ? tag_of(op) : "R11") : tag_in;
        exp_rd = valid && (op inside {5'h08, 5'h09, 5'h0B});
        exp_wr = valid && (op inside {5'h0C, 5'h0D, 5'h0F});
        exp_addr = (op == 5'h08 || op == 5'h0C) ? mr[0] : ma;
        @(negedge clk);
        op_valid = valid; op_code = op; mem_rdata = d;
        #1;
        chk(mem_rd == exp_rd, tag, "mem_rd", 21'(mem_rd), 21'(exp_rd));
        chk(mem_wr == exp_wr, tag, "mem_wr", 21'(mem_wr), 21'(exp_wr));
        if (exp_rd || exp_wr)
            chk(mem_addr == exp_addr, tag, "mem_addr", mem_addr, exp_addr);
        if (exp_wr)
            chk(mem_wdata == mt, tag, "mem_wdata", mem_wdata, mt);
        @(posedge clk);
        #1;
        op_valid = 1'b0;
        if (valid) model_apply(op, d);
        compare_state(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; op_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        #1;
        compare_state("R1");
        chk(!mem_rd && !mem_wr, "R1", "mem strobes", 21'({mem_rd, mem_wr}), 21'd0);
    endtask

    logic [20:0] pt [6] = '{21'h0FFFFF, 21'h155555, 21'h000000, 21'h100001, 21'h0ABCDE, 21'h1FFFFE};
    logic [20:0] ps [6] = '{21'h000001, 21'h0AAAAA, 21'h1FFFFF, 21'h0F0F0F, 21'h012345, 21'h1FFFFF};
    logic [20:0] pa [6] = '{21'h1FFFFF, 21'h000010, 21'h0AAAAA, 21'h155555, 21'h000000, 21'h0FFFFF};
    logic [20:0] pr [6] = '{21'h000020, 21'h1FFFFF, 21'h0FFFFF, 21'h000000, 21'h13579B, 21'h1FFFFE};

    initial begin
        do_reset();

        // sweep of every code over six operand sets
        for (int k = 0; k < 6; k++) begin
            for (int op = 0; op < 32; op++) begin
                step(5'h0A, pa[k], 1'b1, "R9");
                step(5'h1D, 21'h0, 1'b1, "R7");
                step(5'h0A, pr[k], 1'b1, "R9");
                step(5'h1C, 21'h0, 1'b1, "R8");
                step(5'h0A, ps[k], 1'b1, "R9");
                step(5'h0A, pt[k], 1'b1, "R9");
                step(5'(op), pt[k] ^ 21'h0F0F0F, 1'b1, "");
            end
            // strobe low with an active code must do nothing (R11)
            step(5'h10, 21'h1ABCDE, 1'b0, "R11");
            step(5'h1F, 21'h0, 1'b0, "R11");
        end

        // R12: data stack circular overflow and underflow
        do_reset();
        for (int i = 0; i < 20; i++) step(5'h0A, 21'(21'h100 + i), 1'b1, "R12");
        for (int i = 0; i < 19; i++) step(5'h1F, 21'h0, 1'b1, "R12");

        // R12: return stack circular overflow and underflow
        do_reset();
        for (int i = 0; i < 18; i++) begin
            step(5'h0A, 21'(21'h0A000 + i), 1'b1, "R12");
            step(5'h1C, 21'h0, 1'b1, "R12");
        end
        for (int i = 0; i < 18; i++) begin
            step(5'h18, 21'h0, 1'b1, "R12");
            step(5'h1F, 21'h0, 1'b1, "R12");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule